// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable single-port synchronous static memory. Its one data bus carries reads and writes in either direction. A static mode input selects one of two read paths. In pipelined reads the data is registered, so it arrives after the second rising edge. In flow-through reads it is combinational, so it arrives after the first rising edge.

Writes use a late data phase, and its delay equals the read latency of the active mode. A controller can therefore place reads and writes in any order on consecutive cycles with no idle slot between them. Each word is split into 9-bit byte lanes, and a write can update any subset of those lanes.

An active-low clock enable freezes the whole block for wait states. Three chip enables decode the selection. An advance/load input either loads a new address or continues a 4-beat burst from an internal step register, in linear or interleaved order. A write that is still waiting for its data is merged byte by byte into a read of the same word, so the read returns the newest contents.

Top module: `zt_sram`

## Requirements
- R1: After reset no operation is pending and `rdata_oe` is 0.
- R2: A load cycle (`adv_ld`=0) selects the block only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. With any one of these inactive, the cycle neither writes memory nor drives the bus.
- R3: In pipelined mode (`flow_thru`=0), a read registered at enabled edge n drives its data after edge n+1 and not before.
- R4: In flow-through mode (`flow_thru`=1), a read registered at edge n drives its data right after edge n.
- R5: Write data is taken from `wdata` at edge n+2 in pipelined mode and at edge n+1 in flow-through mode. The values on `wdata` at the other edges are ignored.
- R6: Bit i of `byte_we_n` (active low) guards data bits [9i+8:9i]. A write with all four bits high changes no memory.
- R7: While a write holds the bus, `rdata_oe` stays 0 even with `out_en_n`=0.
- R8: `out_en_n`=1 forces `rdata_oe` to 0 at once, without waiting for a clock edge.
- R9: An edge with `clk_en_n`=1 changes no state and no memory. A read that is driving keeps `rdata_oe`=1 and the same data, and a pending write keeps the bus undriven.
- R10: A continue cycle (`adv_ld`=1) keeps the type of the current burst and steps the low two address bits k = 1, 2, 3, 0, … past the loaded start s. The order is (s+k) mod 4 when `interleave`=0 and s XOR k when `interleave`=1. The upper address bits are unchanged, and the sequence wraps after four beats.
- R11: A continue cycle that follows a deselect cycle performs no read and no write.
- R12: In pipelined mode, a read issued one cycle after a write to the same word returns the merged result. Lanes enabled in the write hold the new data, and the other lanes hold the old memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| flow_thru | input | 1 | 1 selects flow-through reads, 0 selects pipelined reads (static) |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write command, active low |
| byte_we_n | input | 4 | Per-lane write enables, active low |
| adv_ld | input | 1 | 0 loads a new command and address, 1 continues the burst |
| addr | input | ADDR_W | Word address |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 36 | Write data half of the bus |
| rdata | output | 36 | Read data half of the bus (0 when not driven) |
| rdata_oe | output | 1 | Bus drive enable |

## Verification
In pipelined mode, read data is due in the cycle after edge n+1 and write data is consumed at edge n+2. In flow-through mode, both are one edge earlier. The bench samples 2 ns after each edge. It checks that the bus is undriven in the cycle before read data is due and that the data is present in the cycle it is due. It places deliberately wrong values on `wdata` at the edges where the write data must not be taken. Frozen edges, bursts and deselect-continue cycles are followed by reads that show the stored words are as the requirements predict.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    // Width of the burst step counter: four beats per burst.
    localparam int BURST_BITS = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/zt_sram_burst.sv
// Produces the address of the current burst beat from the loaded start
// address and the beat number.
module zt_sram_burst
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0]     base_addr,
    input  logic [BURST_BITS-1:0] step,
    input  logic                  interleave,
    output logic [ADDR_W-1:0]     beat_addr
);

    logic [BURST_BITS-1:0] low_bits;

    always_comb begin
        if (interleave) begin
            low_bits = base_addr[BURST_BITS-1:0] ^ step;
        end else begin
            low_bits = base_addr[BURST_BITS-1:0] + step;
        end
    end

    generate
        if (ADDR_W > BURST_BITS) begin : g_upper
            assign beat_addr = {base_addr[ADDR_W-1:BURST_BITS], low_bits};
        end else begin : g_narrow
            assign beat_addr = low_bits[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/zt_sram_mem.sv
// Storage array: one array per byte lane, with a lane-masked synchronous
// write port and an asynchronous read port.
module zt_sram_mem #(
    parameter int ADDR_W    = 6,
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 9
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [NUM_LANES-1:0]          wr_lanes,
    input  logic [NUM_LANES*LANE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [NUM_LANES*LANE_W-1:0]   rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            logic [LANE_W-1:0] lane_mem [DEPTH];

            always_ff @(posedge clk) begin
                if (wr_en && wr_lanes[g]) begin
                    lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
                end
            end

            assign rd_data[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
        end
    endgenerate

endmodule

// File: rtl/zt_sram_merge.sv
// Lane-wise select between stored data and newer write data.
module zt_sram_merge #(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 9
) (
    input  logic [NUM_LANES*LANE_W-1:0] stored,
    input  logic [NUM_LANES*LANE_W-1:0] newer,
    input  logic [NUM_LANES-1:0]        take_new,
    output logic [NUM_LANES*LANE_W-1:0] merged
);

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            assign merged[g*LANE_W +: LANE_W] = take_new[g] ?
                newer[g*LANE_W +: LANE_W] : stored[g*LANE_W +: LANE_W];
        end
    endgenerate

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flow_thru,
    input  logic                          interleave,
    input  logic                          clk_en_n,
    input  logic                          ce1_n,
    input  logic                          ce2,
    input  logic                          ce3_n,
    input  logic                          we_n,
    input  logic [NUM_LANES-1:0]          byte_we_n,
    input  logic                          adv_ld,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          out_en_n,
    input  logic [NUM_LANES*LANE_W-1:0]   wdata,
    output logic [NUM_LANES*LANE_W-1:0]   rdata,
    output logic                          rdata_oe
);

    localparam int DATA_W = NUM_LANES * LANE_W;

    typedef struct packed {
        op_e                   burst_op;
        logic [ADDR_W-1:0]     burst_base;
        logic [BURST_BITS-1:0] burst_step;
        op_e                   s1_op;
        logic [ADDR_W-1:0]     s1_addr;
        logic [NUM_LANES-1:0]  s1_lanes;
        op_e                   s2_op;
        logic [ADDR_W-1:0]     s2_addr;
        logic [NUM_LANES-1:0]  s2_lanes;
        logic [DATA_W-1:0]     q_data;
    } state_t;

    state_t st_q, st_d;

    logic                  selected;
    logic [BURST_BITS-1:0] next_step;
    logic [ADDR_W-1:0]     cont_addr;
    logic [DATA_W-1:0]     mem_rd;
    logic [DATA_W-1:0]     merged;
    logic [NUM_LANES-1:0]  bypass_lanes;
    op_e                   commit_op;
    logic [ADDR_W-1:0]     commit_addr;
    logic [NUM_LANES-1:0]  commit_lanes;
    logic                  commit_en;
    logic                  drive;

    assign selected  = !ce1_n && ce2 && !ce3_n;
    assign next_step = st_q.burst_step + {{(BURST_BITS-1){1'b0}}, 1'b1};

    zt_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .base_addr (st_q.burst_base),
        .step      (next_step),
        .interleave(interleave),
        .beat_addr (cont_addr)
    );

    // Commit point: flow-through writes retire from stage 1, pipelined from stage 2.
    always_comb begin
        if (flow_thru) begin
            commit_op    = st_q.s1_op;
            commit_addr  = st_q.s1_addr;
            commit_lanes = st_q.s1_lanes;
        end else begin
            commit_op    = st_q.s2_op;
            commit_addr  = st_q.s2_addr;
            commit_lanes = st_q.s2_lanes;
        end
    end

    assign commit_en = !clk_en_n && (commit_op == OP_WRITE);

    zt_sram_mem #(
        .ADDR_W   (ADDR_W),
        .NUM_LANES(NUM_LANES),
        .LANE_W   (LANE_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (commit_en),
        .wr_addr (commit_addr),
        .wr_lanes(commit_lanes),
        .wr_data (wdata),
        .rd_addr (st_q.s1_addr),
        .rd_data (mem_rd)
    );

    // A pipelined read captured while the previous write commits sees its lanes.
    always_comb begin
        if (!flow_thru && (st_q.s2_op == OP_WRITE) && (st_q.s2_addr == st_q.s1_addr)) begin
            bypass_lanes = st_q.s2_lanes;
        end else begin
            bypass_lanes = '0;
        end
    end

    zt_sram_merge #(
        .NUM_LANES(NUM_LANES),
        .LANE_W   (LANE_W)
    ) u_merge (
        .stored  (mem_rd),
        .newer   (wdata),
        .take_new(bypass_lanes),
        .merged  (merged)
    );

    always_comb begin
        st_d = st_q;
        if (!clk_en_n) begin
            st_d.s2_op    = st_q.s1_op;
            st_d.s2_addr  = st_q.s1_addr;
            st_d.s2_lanes = st_q.s1_lanes;
            if (st_q.s1_op == OP_READ) begin
                st_d.q_data = merged;
            end
            if (!adv_ld) begin
                st_d.burst_step = '0;
                st_d.burst_base = addr;
                st_d.s1_addr    = addr;
                if (selected) begin
                    st_d.burst_op = we_n ? OP_READ : OP_WRITE;
                    st_d.s1_op    = we_n ? OP_READ : OP_WRITE;
                    st_d.s1_lanes = we_n ? '0 : ~byte_we_n;
                end else begin
                    st_d.burst_op = OP_NONE;
                    st_d.s1_op    = OP_NONE;
                    st_d.s1_lanes = '0;
                end
            end else begin
                st_d.burst_step = next_step;
                st_d.s1_op      = st_q.burst_op;
                st_d.s1_addr    = cont_addr;
                st_d.s1_lanes   = (st_q.burst_op == OP_WRITE) ? ~byte_we_n : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign drive    = flow_thru ? (st_q.s1_op == OP_READ) : (st_q.s2_op == OP_READ);
    assign rdata_oe = drive && !out_en_n;
    assign rdata    = rdata_oe ? (flow_thru ? mem_rd : st_q.q_data) : '0;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int ADDR_W    = 6,
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 9
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        flow_thru,
    input logic                        clk_en_n,
    input logic                        ce1_n,
    input logic                        ce2,
    input logic                        ce3_n,
    input logic                        we_n,
    input logic                        adv_ld,
    input logic                        out_en_n,
    input logic [NUM_LANES*LANE_W-1:0] rdata,
    input logic                        rdata_oe
);

    logic [1:0] seen;
    logic       sel_now;
    logic       rd_cmd;
    logic       wr_cmd;
    logic       desel_cmd;

    assign sel_now   = !ce1_n && ce2 && !ce3_n;
    assign rd_cmd    = !clk_en_n && !adv_ld && sel_now && we_n;
    assign wr_cmd    = !clk_en_n && !adv_ld && sel_now && !we_n;
    assign desel_cmd = !clk_en_n && !adv_ld && !sel_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (seen != 2'd3) begin
            seen <= seen + 2'd1;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd0) |-> !rdata_oe);

    a_r2_deselect_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1 && flow_thru && $past(desel_cmd)) |-> !rdata_oe);

    a_r3_pipe_read_due: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && !flow_thru && !out_en_n && $past(rd_cmd, 2) && $past(!clk_en_n))
        |-> rdata_oe);

    a_r4_flow_read_due: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1 && flow_thru && !out_en_n && $past(rd_cmd)) |-> rdata_oe);

    a_r7_pipe_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && !flow_thru && $past(wr_cmd, 2) && $past(!clk_en_n)) |-> !rdata_oe);

    a_r7_flow_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1 && flow_thru && $past(wr_cmd)) |-> !rdata_oe);

    a_r8_oe_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rdata_oe);

    a_r9_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1 && $past(clk_en_n) && $past(rdata_oe) && !out_en_n && $stable(flow_thru))
        |-> (rdata_oe && $stable(rdata)));

endmodule

bind zt_sram zt_sram_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_LANES(NUM_LANES),
    .LANE_W   (LANE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flow_thru(flow_thru),
    .clk_en_n (clk_en_n),
    .ce1_n    (ce1_n),
    .ce2      (ce2),
    .ce3_n    (ce3_n),
    .we_n     (we_n),
    .adv_ld   (adv_ld),
    .out_en_n (out_en_n),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
);

// File: tb/tb_zt_sram.sv
module tb_zt_sram;

    localparam int K_IDLE = 0;
    localparam int K_RD   = 1;
    localparam int K_WR   = 2;
    localparam int K_CONT = 3;

    typedef struct packed {
        logic [5:0]  a;
        logic [3:0]  ben;
        logic [35:0] d;
    } vec_t;

    // Pipelined write followed at once by a read of the same word.
    localparam vec_t VECS [8] = '{
        '{6'd3,  4'b0000, 36'h1_2345_6789},
        '{6'd3,  4'b1110, 36'hF_FFFF_F0AB},
        '{6'd40, 4'b0111, 36'hA_BC00_0000},
        '{6'd40, 4'b1010, 36'h0_5A5A_5A5A},
        '{6'd17, 4'b0101, 36'h9_8765_4321},
        '{6'd17, 4'b1111, 36'h0_0000_0000},
        '{6'd63, 4'b1101, 36'h7_7777_7777},
        '{6'd0,  4'b0011, 36'hC_0FFE_E123}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flow_thru = 1'b1;
    logic        interleave = 1'b0;
    logic        clk_en_n = 1'b0;
    logic        ce1_n = 1'b1;
    logic        ce2 = 1'b1;
    logic        ce3_n = 1'b0;
    logic        we_n = 1'b1;
    logic [3:0]  byte_we_n = 4'hF;
    logic        adv_ld = 1'b0;
    logic [5:0]  addr = '0;
    logic        out_en_n = 1'b0;
    logic [35:0] wdata = '0;
    logic [35:0] rdata;
    logic        rdata_oe;

    logic [35:0] ref_mem [64];
    int          checks = 0;
    int          failures = 0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    zt_sram dut (
        .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .interleave(interleave),
        .clk_en_n(clk_en_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n),
        .byte_we_n(byte_we_n), .adv_ld(adv_ld), .addr(addr), .out_en_n(out_en_n),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    function automatic logic [35:0] pat(input logic [5:0] a);
        return {a, ~a, 24'h3C0000 + {18'd0, a}};
    endfunction

    function automatic logic [35:0] merge(input logic [35:0] old_w, input logic [35:0] new_w,
                                          input logic [3:0] ben);
        logic [35:0] r = old_w;
        for (int l = 0; l < 4; l++) begin
            if (!ben[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
        end
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic cmd(input int kind, input logic [5:0] a, input logic [3:0] ben);
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        addr = a; byte_we_n = ben; we_n = 1'b1; adv_ld = 1'b0;
        case (kind)
            K_IDLE: ce1_n = 1'b1;
            K_WR:   we_n = 1'b0;
            K_CONT: begin adv_ld = 1'b1; ce1_n = 1'b1; end
            default: ;
        endcase
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_word(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Flow-through read of one word; data is due right after the edge.
    task automatic flow_read(input string req, input logic [5:0] a);
        cmd(K_RD, a, 4'hF);
        tick();
        chk_bit(req, rdata_oe, 1'b1);
        chk_word(req, rdata, ref_mem[a]);
        cmd(K_IDLE, 6'd0, 4'hF);
    endtask

    task automatic drain();
        cmd(K_IDLE, 6'd0, 4'hF);
        tick();
        tick();
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [35:0] held;
        logic [35:0] exp_w;

        cmd(K_IDLE, 6'd0, 4'hF);
        repeat (3) tick();
        chk_bit("R1 bus undriven in reset", rdata_oe, 1'b0);
        rst_n = 1'b1;
        tick();
        chk_bit("R1 bus undriven after reset", rdata_oe, 1'b0);

        // Fill memory in flow-through mode.
        for (int a = 0; a < 64; a++) begin
            cmd(K_WR, 6'(a), 4'h0);
            tick();
            cmd(K_IDLE, 6'd0, 4'hF);
            wdata = pat(6'(a));
            ref_mem[a] = pat(6'(a));
            tick();
        end
        flow_read("R4 flow read of filled word", 6'd12);
        flow_read("R4 flow read of filled word", 6'd63);

        // Vector table: pipelined write, read one cycle later, bypass merge.
        flow_thru = 1'b0;
        drain();
        for (int i = 0; i < 8; i++) begin
            cmd(K_WR, VECS[i].a, VECS[i].ben);
            tick();
            cmd(K_RD, VECS[i].a, 4'hF);
            wdata = ~VECS[i].d;             // must be ignored at edge n+1 (R5)
            tick();
            chk_bit("R7 pipelined write leaves bus undriven", rdata_oe, 1'b0);
            cmd(K_IDLE, 6'd0, 4'hF);
            wdata = VECS[i].d;
            tick();
            exp_w = merge(ref_mem[VECS[i].a], VECS[i].d, VECS[i].ben);
            ref_mem[VECS[i].a] = exp_w;
            wdata = ~VECS[i].d;
            chk_bit("R12 read after write driven", rdata_oe, 1'b1);
            chk_word("R12 R5 R6 merged read after write", rdata, exp_w);
        end

        // Pipelined read latency (R3).
        cmd(K_RD, 6'd40, 4'hF);
        tick();
        cmd(K_IDLE, 6'd0, 4'hF);
        chk_bit("R3 no data after first edge", rdata_oe, 1'b0);
        tick();
        chk_bit("R3 data after second edge", rdata_oe, 1'b1);
        chk_word("R3 pipelined read data", rdata, ref_mem[40]);

        // Asynchronous output enable (R8).
        cmd(K_RD, 6'd17, 4'hF);
        tick();
        cmd(K_IDLE, 6'd0, 4'hF);
        tick();
        out_en_n = 1'b1;
        #1;
        chk_bit("R8 out_en_n high forces off", rdata_oe, 1'b0);
        out_en_n = 1'b0;
        #1;
        chk_bit("R8 drive restored", rdata_oe, 1'b1);

        // Freeze during a pipelined read (R9).
        cmd(K_RD, 6'd3, 4'hF);
        tick();
        cmd(K_IDLE, 6'd0, 4'hF);
        tick();
        held = rdata;
        chk_word("R9 read before freeze", held, ref_mem[3]);
        clk_en_n = 1'b1;
        cmd(K_WR, 6'd3, 4'h0);
        wdata = 36'hD_EAD0_BEEF;
        tick();
        chk_bit("R9 frozen read stays driven", rdata_oe, 1'b1);
        tick();
        chk_word("R9 frozen read data held", rdata, held);
        clk_en_n = 1'b0;
        cmd(K_IDLE, 6'd0, 4'hF);
        tick();
        chk_bit("R9 read ends after release", rdata_oe, 1'b0);

        // Freeze during a pipelined write (R9).
        cmd(K_WR, 6'd50, 4'h0);
        tick();
        cmd(K_IDLE, 6'd0, 4'hF);
        tick();
        clk_en_n = 1'b1;
        wdata = 36'hB_AD00_0BAD;
        tick();
        chk_bit("R9 frozen write keeps bus undriven", rdata_oe, 1'b0);
        tick();
        clk_en_n = 1'b0;
        wdata = 36'h2_4681_3579;
        ref_mem[50] = 36'h2_4681_3579;
        tick();
        wdata = '0;
        drain();
        flow_thru = 1'b1;
        drain();
        flow_read("R9 write after freeze takes released data", 6'd50);
        flow_read("R9 frozen write did not touch word 3", 6'd3);

        // Flow-through write timing (R5).
        cmd(K_WR, 6'd7, 4'h0);
        tick();
        cmd(K_IDLE, 6'd0, 4'hF);
        wdata = 36'h1_1111_2222;
        ref_mem[7] = 36'h1_1111_2222;
        tick();
        wdata = 36'hE_EEEE_EEEE;
        flow_read("R5 flow write data taken at n+1", 6'd7);

        // Deselect decoding (R2).
        for (int v = 0; v < 3; v++) begin
            cmd(K_WR, 6'd9, 4'h0);
            if (v == 0) ce1_n = 1'b1;
            if (v == 1) ce2 = 1'b0;
            if (v == 2) ce3_n = 1'b1;
            tick();
            cmd(K_IDLE, 6'd0, 4'hF);
            wdata = 36'hF_0F0F_0F0F;
            tick();
            flow_read("R2 deselected write ignored", 6'd9);
        end
        cmd(K_RD, 6'd9, 4'hF);
        ce2 = 1'b0;
        tick();
        chk_bit("R2 deselected read not driven", rdata_oe, 1'b0);

        // Linear burst read, start 10 (R10).
        interleave = 1'b0;
        cmd(K_RD, 6'd10, 4'hF);
        tick();
        chk_word("R10 linear beat 0", rdata, ref_mem[10]);
        cmd(K_CONT, 6'd0, 4'hF);
        tick(); chk_word("R10 linear beat 1", rdata, ref_mem[11]);
        tick(); chk_word("R10 linear beat 2", rdata, ref_mem[8]);
        tick(); chk_word("R10 linear beat 3", rdata, ref_mem[9]);
        tick(); chk_word("R10 linear wrap", rdata, ref_mem[10]);

        // Interleaved burst read, start 21 (R10).
        interleave = 1'b1;
        cmd(K_RD, 6'd21, 4'hF);
        tick();
        chk_word("R10 interleaved beat 0", rdata, ref_mem[21]);
        cmd(K_CONT, 6'd0, 4'hF);
        tick(); chk_word("R10 interleaved beat 1", rdata, ref_mem[20]);
        tick(); chk_word("R10 interleaved beat 2", rdata, ref_mem[23]);
        tick(); chk_word("R10 interleaved beat 3", rdata, ref_mem[22]);
        interleave = 1'b0;
        drain();

        // Pipelined linear burst write from 35: words 35, 32, 33, 34 (R10).
        flow_thru = 1'b0;
        drain();
        cmd(K_WR, 6'd35, 4'h0);
        tick();
        cmd(K_CONT, 6'd0, 4'h0);
        tick();
        for (int k = 0; k < 4; k++) begin
            if (k >= 2) cmd(K_IDLE, 6'd0, 4'hF);
            wdata = 36'h0_ABCD_0000 + 36'(k);
            tick();
        end
        ref_mem[35] = 36'h0_ABCD_0000;
        ref_mem[32] = 36'h0_ABCD_0001;
        ref_mem[33] = 36'h0_ABCD_0002;
        ref_mem[34] = 36'h0_ABCD_0003;
        drain();
        flow_thru = 1'b1;
        drain();
        flow_read("R10 burst write beat 0", 6'd35);
        flow_read("R10 burst write beat 1", 6'd32);
        flow_read("R10 burst write beat 2", 6'd33);
        flow_read("R10 burst write beat 3", 6'd34);

        // Continue after deselect (R11).
        cmd(K_IDLE, 6'd33, 4'hF);
        tick();
        cmd(K_CONT, 6'd0, 4'h0);
        we_n = 1'b0;
        tick();
        chk_bit("R11 continue after deselect not driven", rdata_oe, 1'b0);
        wdata = 36'h3_3333_3333;
        tick();
        wdata = 36'h4_4444_4444;
        cmd(K_IDLE, 6'd0, 4'hF);
        tick();
        flow_read("R11 no write from deselect continue", 6'd34);
        flow_read("R11 no write from deselect continue", 6'd35);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule